// File: doc/BRIEF.md
# Dual-Channel PWM with Paired Timebase

This block drives two PWM outputs from one shared timebase prescaler. A register-style write port carries a channel index, an enable bit and a 4-bit clock code. The low three bits of the code pick the timebase. Values 0 to 6 divide the system clock, and value 7 takes ticks from an external clock pin. Bit 3 of the code picks the period length, which is either a short period or a long period measured in timebase ticks.

There is only one prescaler. Writing a code to one channel therefore also moves the other channel onto the new timebase. The other channel keeps its own period group, so its code is rewritten silently. Two channels can differ in frequency only when one is in the short group and the other is in the long group. Each channel has a duty input that is sampled continuously. Enable, period group and duty are adopted only at the start of a new period, so no pulse is ever cut short.

Top module: `pwm_pair`

## Requirements
- R1: After reset, both channels are disabled, both codes are 0, and both outputs are low.
- R2: A write with `cfg_ch_i` = 1 configures channel A and `cfg_ch_i` = 2 configures channel B. Writes with index 0 or 3 change nothing.
- R3: When code bits [2:0] equal k, with k from 0 to 6, the timebase ticks once every 2^(k+1) system clock cycles.
- R4: When code bits [2:0] equal 7, every rising edge of `ext_clk_i` gives one tick, after a two-flop synchroniser.
- R5: When code bit 3 is 0, the period is 2^SHORT_W ticks and the compare value is the upper SHORT_W bits of the duty input. When code bit 3 is 1, the period is 2^LONG_W ticks and the compare value is the full duty. The output is high for exactly compare-value ticks at the start of each period.
- R6: A valid write sets the addressed channel's code to the written value. The other channel's code becomes {its own bit 3, the written bits [2:0]}. Both channels then share one timebase.
- R7: A disabled channel drives its output low and holds its period counter at zero. Once the channel is enabled, it starts a fresh period at count zero.
- R8: Changes to enable, period group and duty take effect only at the next period boundary of the channel. Every pulse therefore has either the old width or the new width and never a truncated one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Channel index: 1 = A, 2 = B |
| cfg_en_i | input | 1 | Enable for the addressed channel |
| cfg_code_i | input | 4 | Clock code: [2:0] timebase, [3] period group |
| duty_a_i | input | LONG_W | Duty compare value, channel A |
| duty_b_i | input | LONG_W | Duty compare value, channel B |
| ext_clk_i | input | 1 | External timebase clock, asynchronous |
| pwm_a_o | output | 1 | PWM output A |
| pwm_b_o | output | 1 | PWM output B |

## Verification
- **Write latency.** A write reaches the code registers on the next clock.
- **Output latency.** Each output is registered, so it lags its period counter by one cycle.
- **Latency of enable, group and duty.** These are adopted at the channel's next period boundary, which can be up to a full long period away.

The bench therefore waits out twice the longest period of the old and new settings after every change. The longer timebase of the two settings sets the tick length for this wait. The bench then counts high cycles over a window made of whole periods, so the expected count does not depend on the phase of the prescaler or the counters.

The boundary rule is checked directly. The bench changes the duty halfway through a pulse and then confirms that every following pulse has either the old width or the new width.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int CODE_W = 4;
  localparam int SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_EXT = 3'd7;

  typedef logic [CODE_W-1:0] clk_code_t;

  // Partner code: keep own period group, follow the written timebase
  function automatic clk_code_t follow_code(clk_code_t own, clk_code_t written);
    return {own[CODE_W-1], written[SEL_W-1:0]};
  endfunction
endpackage

// File: rtl/pwm_pair_cfg.sv
module pwm_pair_cfg
  import pwm_pair_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [1:0]            ch_i,
  input  logic                  en_i,
  input  clk_code_t             code_i,
  output logic [1:0]            en_o,
  output logic [1:0][CODE_W-1:0] code_o,
  output logic [SEL_W-1:0]      sel_o
);
  logic       wr_ok;
  logic       wr_idx;
  logic [1:0] en_q;
  logic [1:0][CODE_W-1:0] code_q;

  assign wr_ok  = wr_i && ((ch_i == 2'd1) || (ch_i == 2'd2));
  assign wr_idx = ch_i[1];

  for (genvar i = 0; i < 2; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        code_q[i] <= '0;
      end else if (wr_ok) begin
        if (wr_idx == 1'(i)) begin
          en_q[i]   <= en_i;
          code_q[i] <= code_i;
        end else begin
          code_q[i] <= follow_code(code_q[i], code_i);
        end
      end
    end
  end

  assign en_o   = en_q;
  assign code_o = code_q;
  assign sel_o  = code_q[0][SEL_W-1:0];
endmodule

// File: rtl/pwm_pair_timebase.sv
module pwm_pair_timebase
  import pwm_pair_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_clk_i,
  output logic             tick_o
);
  localparam int PRE_W = 7;  // largest internal divide is 2^7

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;
  logic ext_meta, ext_sync, ext_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt  <= '0;
      ext_meta <= 1'b0;
      ext_sync <= 1'b0;
      ext_prev <= 1'b0;
    end else begin
      pre_cnt  <= pre_cnt + PRE_W'(1);
      ext_meta <= ext_clk_i;
      ext_sync <= ext_meta;
      ext_prev <= ext_sync;
    end
  end

  // sel 6 shifts out to zero, so the mask becomes all ones
  assign mask = (PRE_W'(1) << (sel_i + 3'd1)) - PRE_W'(1);

  always_comb begin
    if (sel_i == SEL_EXT) tick_o = ext_sync && !ext_prev;
    else                  tick_o = (pre_cnt & mask) == mask;
  end
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan #(
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              long_i,
  input  logic [LONG_W-1:0] duty_i,
  output logic              pwm_o,
  output logic              act_en_o,
  output logic              act_long_o,
  output logic [LONG_W-1:0] cnt_o
);
  localparam logic [LONG_W-1:0] SHORT_LAST = LONG_W'((1 << SHORT_W) - 1);

  logic              act_en, act_long, pwm_q, last, bnd;
  logic [LONG_W-1:0] act_duty, cnt, cmp;

  always_comb begin
    last = act_long ? (cnt == '1) : (cnt == SHORT_LAST);
    bnd  = !act_en || (tick_i && last);
    cmp  = act_long ? act_duty : LONG_W'(act_duty[LONG_W-1 -: SHORT_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en   <= 1'b0;
      act_long <= 1'b0;
      act_duty <= '0;
      cnt      <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (bnd) begin
        act_en   <= en_i;
        act_long <= long_i;
        act_duty <= duty_i;
        cnt      <= '0;
      end else if (tick_i) begin
        cnt <= cnt + LONG_W'(1);
      end
      pwm_q <= act_en && (cnt < cmp);
    end
  end

  assign pwm_o      = pwm_q;
  assign act_en_o   = act_en;
  assign act_long_o = act_long;
  assign cnt_o      = cnt;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [1:0]        cfg_ch_i,
  input  logic              cfg_en_i,
  input  logic [3:0]        cfg_code_i,
  input  logic [LONG_W-1:0] duty_a_i,
  input  logic [LONG_W-1:0] duty_b_i,
  input  logic              ext_clk_i,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);
  logic [1:0]              en, act_en, act_long, pwm;
  logic [1:0][CODE_W-1:0]  code;
  logic [1:0][LONG_W-1:0]  duty, cnt;
  logic [SEL_W-1:0]        sel;
  logic                    tick;

  assign duty = {duty_b_i, duty_a_i};

  pwm_pair_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .ch_i   (cfg_ch_i),
    .en_i   (cfg_en_i),
    .code_i (cfg_code_i),
    .en_o   (en),
    .code_o (code),
    .sel_o  (sel)
  );

  pwm_pair_timebase u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .ext_clk_i (ext_clk_i),
    .tick_o    (tick)
  );

  for (genvar i = 0; i < 2; i++) begin : g_ch
    pwm_pair_chan #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .en_i       (en[i]),
      .long_i     (code[i][CODE_W-1]),
      .duty_i     (duty[i]),
      .pwm_o      (pwm[i]),
      .act_en_o   (act_en[i]),
      .act_long_o (act_long[i]),
      .cnt_o      (cnt[i])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];
endmodule

// File: rtl/pwm_pair_chk.sv
module pwm_pair_chk #(
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 15
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cfg_wr_i,
  input logic [1:0]             cfg_ch_i,
  input logic [1:0][3:0]        code_i,
  input logic [1:0]             act_en_i,
  input logic [1:0]             act_long_i,
  input logic [1:0][LONG_W-1:0] cnt_i,
  input logic [1:0]             pwm_i
);
  localparam logic [LONG_W-1:0] SHORT_LAST = LONG_W'((1 << SHORT_W) - 1);

  // R6
  pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_i[0][2:0] == code_i[1][2:0]);

  // R2
  bad_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && (cfg_ch_i == 2'd0 || cfg_ch_i == 2'd3)) |=> $stable(code_i));

  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R7
    off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_en_i[i] |=> !pwm_i[i]);
    // R7
    off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_en_i[i] |-> cnt_i[i] == '0);
    // R5
    short_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_long_i[i] |-> cnt_i[i] <= SHORT_LAST);
    // R8
    group_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_long_i[i]) |-> cnt_i[i] == '0);
  end
endmodule

bind pwm_pair pwm_pair_chk #(.SHORT_W(SHORT_W), .LONG_W(LONG_W)) i_pwm_pair_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_wr_i   (cfg_wr_i),
  .cfg_ch_i   (cfg_ch_i),
  .code_i     (code),
  .act_en_i   (act_en),
  .act_long_i (act_long),
  .cnt_i      (cnt),
  .pwm_i      (pwm)
);

// File: tb/test_pwm_pair.sv
module test_pwm_pair;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;
  localparam int LW = 7;
  localparam int EXT_TICK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_en = 1'b0, ext_clk = 1'b0;
  logic [1:0] cfg_ch = 2'd0;
  logic [3:0] cfg_code = 4'd0;
  logic [LW-1:0] duty_a = '0, duty_b = '0;
  logic pwm_a, pwm_b;

  int checks = 0, bad = 0;
  bit done = 1'b0;
  logic [3:0] m_code [2];
  bit m_en [2];
  int p_old = 1 << SW, s_old = 2;
  int ext_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ext_div == EXT_TICK/2 - 1) begin ext_div <= 0; ext_clk <= ~ext_clk; end
    else ext_div <= ext_div + 1;
  end

  pwm_pair #(.SHORT_W(SW), .LONG_W(LW)) i_pwm_pair (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_ch_i(cfg_ch),
    .cfg_en_i(cfg_en), .cfg_code_i(cfg_code), .duty_a_i(duty_a), .duty_b_i(duty_b),
    .ext_clk_i(ext_clk), .pwm_a_o(pwm_a), .pwm_b_o(pwm_b)
  );

  function automatic int sc_of(logic [2:0] s);
    return (s == 3'd7) ? EXT_TICK : (2 << s);
  endfunction
  function automatic int plen(logic [3:0] c);
    return c[3] ? (1 << LW) : (1 << SW);
  endfunction
  function automatic int cmp_of(logic [3:0] c, logic [LW-1:0] d);
    return c[3] ? int'(d) : int'(d[LW-1 -: SW]);
  endfunction
  function automatic int max_p();
    int p = 1 << SW;
    for (int i = 0; i < 2; i++) if (m_en[i] && plen(m_code[i]) > p) p = plen(m_code[i]);
    return p;
  endfunction
  function automatic int exp_high(int i, logic [LW-1:0] d, int win, int sc);
    if (!m_en[i]) return 0;
    return (win / (plen(m_code[i]) * sc)) * cmp_of(m_code[i], d) * sc;
  endfunction

  task automatic check(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(int ch, bit en, logic [3:0] c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_ch = 2'(ch); cfg_en = en; cfg_code = c;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (ch == 1 || ch == 2) begin
      m_code[ch-1] = c;
      m_en[ch-1] = en;
      m_code[2-ch] = {m_code[2-ch][3], c[2:0]};
    end
  endtask

  task automatic apply_check(string tag);
    int pn = max_p();
    int sn = sc_of(m_code[0][2:0]);
    int pm = (pn > p_old) ? pn : p_old;
    int sm = (sn > s_old) ? sn : s_old;
    int win = pn * sn;
    int ha = 0, hb = 0;
    run(2 * pm * sm + 8);
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (pwm_b) hb++;
    end
    check(ha, exp_high(0, duty_a, win, sn), {tag, " chA"});
    check(hb, exp_high(1, duty_b, win, sn), {tag, " chB"});
    p_old = pn; s_old = sn;
  endtask

  // R8: change duty mid-pulse; every pulse must be old or new width
  task automatic pulse_check(logic [LW-1:0] nd, int old_len, int new_len);
    int lens [4];
    int n = 0, len = 0;
    bit prev = 1'b1, started = 1'b0, changed = 1'b0;
    while (n < 4) begin
      @(negedge clk);
      if (pwm_a && !prev) begin len = 1; started = 1'b1; end
      else if (pwm_a) len++;
      if (started && pwm_a && len == 4 && !changed) begin duty_a = nd; changed = 1'b1; end
      if (started && !pwm_a && prev) begin lens[n] = len; n++; end
      prev = pwm_a;
    end
    for (int k = 0; k < 4; k++)
      check((lens[k] == old_len || lens[k] == new_len) ? 1 : 0, 1, "R8 whole pulse width");
    check(lens[0], old_len, "R8 pulse in progress keeps width");
    check(lens[3], new_len, "R8 new width adopted");
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int ha = 0, hb = 0;
    m_code[0] = 4'd0; m_code[1] = 4'd0; m_en[0] = 1'b0; m_en[1] = 1'b0;
    void'($urandom(32'd4711));
    run(4);
    rst_n = 1'b1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (pwm_b) hb++;
    end
    check(ha, 0, "R1 reset chA low");
    check(hb, 0, "R1 reset chB low");

    duty_a = 7'h53;                       // short compare 10
    cfg_write(1, 1'b1, 4'd0);
    apply_check("R3 R5 short group code 0");

    pulse_check(7'h18, 20, 6);            // compare 10 -> 3, 2 cycles per tick
    p_old = 1 << SW; s_old = 2;

    duty_b = 7'd45;
    cfg_write(2, 1'b1, 4'd8);
    apply_check("R5 R6 codes 0 and 8 differ");

    cfg_write(2, 1'b1, 4'd10);
    check(int'(m_code[0]), 2, "R6 model remap A to 2");
    apply_check("R6 A follows to code 2");

    cfg_write(1, 1'b1, 4'd3);
    apply_check("R6 B follows to code 11");

    cfg_write(0, 1'b0, 4'd5);
    cfg_write(3, 1'b0, 4'd9);
    apply_check("R2 index 0 and 3 ignored");

    duty_a = 7'h00; duty_b = 7'h7F;
    apply_check("R5 zero and full duty");

    duty_a = 7'h6A;
    cfg_write(1, 1'b1, 4'd7);
    apply_check("R4 external clock ticks");

    cfg_write(1, 1'b0, 4'd7);
    apply_check("R7 disabled A low");

    duty_b = 7'h2C;
    cfg_write(2, 1'b1, 4'd0);
    apply_check("R3 B back to code 0");
    cfg_write(2, 1'b1, 4'd6);
    apply_check("R3 slowest internal timebase");

    duty_a = 7'h7F;
    cfg_write(1, 1'b1, 4'd6);
    apply_check("R7 re-enable A");

    cfg_write(1, 1'b1, 4'd0);
    cfg_write(2, 1'b1, 4'd0);
    apply_check("R3 return to fast");

    for (int it = 0; it < 10; it++) begin
      int ch = $urandom_range(1, 2);
      logic [3:0] c = 4'($urandom_range(0, 3) + 8 * $urandom_range(0, 1));
      bit en = ($urandom_range(0, 3) != 0);
      duty_a = LW'($urandom_range(0, (1 << LW) - 1));
      duty_b = LW'($urandom_range(0, (1 << LW) - 1));
      cfg_write(ch, en, c);
      apply_check("R5 R6 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule